// File: doc/BRIEF.md
# Command Prefetch Front End with Engine Queue

This block is the entry point of a two-stage command pipeline. A parser stage is the only consumer of the incoming command stream. It decodes each command's 4-bit opcode and does one of three things. A simple register-write command is retired on the spot through a local write port. A synchronisation command holds the parser until the downstream engine has caught up. Every other command is pushed into a small queue that feeds the execution engine.

The parser can run ahead of the engine by up to the depth of the queue, and input backpressure appears only when that limit would be exceeded. A synchronisation command is the only point where the two stages are brought back in step. The parser accepts it, stops taking input, and waits until the queue is empty and the engine reports that it is idle.

Top module: `cmd_frontend`

## Requirements
- R1: After reset, in_ready_o is 1, eng_valid_o is 0, fifo_empty_o is 1, fifo_full_o is 0, sync_wait_o is 0 and reg_we_o is 0.
- R2: A command with opcode 0 to 3 that is accepted makes reg_we_o high exactly one cycle later, with reg_addr_o equal to the opcode and reg_data_o equal to the payload. The command never reaches the engine port.
- R3: Commands with opcodes 4 to 14 appear on the engine port in their order of acceptance, with opcode and payload unchanged, and each appears once. eng_valid_o is high exactly when the queue holds at least one entry.
- R4: The queue holds at most DEPTH entries (8 by default). While it is full and a command with opcode 4 to 14 is presented, in_ready_o is 0.
- R5: A local command (opcode 0 to 3) is accepted even when the queue is full or non-empty, as long as no synchronisation is pending.
- R6: Opcode 15 is the synchronisation command. Once it is accepted, sync_wait_o is 1 and in_ready_o is 0 from the next cycle onward. The command is neither forwarded nor written locally.
- R7: sync_wait_o falls on the clock edge at which the queue is empty and eng_idle_i is 1. in_ready_o returns in the cycle that follows that edge.
- R8: fifo_empty_o is 1 exactly when the queue holds zero entries, and fifo_full_o is 1 exactly when it holds DEPTH entries.
- R9: While eng_valid_o is 1 and eng_ready_i is 0, the head entry on eng_opcode_o and eng_payload_o stays unchanged and eng_valid_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Incoming command valid |
| in_ready_o | output | 1 | Parser can accept the command presented |
| in_opcode_i | input | 4 | Command opcode |
| in_payload_i | input | PAY_W | Command payload |
| eng_valid_o | output | 1 | Queue head valid toward the engine |
| eng_ready_i | input | 1 | Engine takes the head entry |
| eng_opcode_o | output | 4 | Head entry opcode |
| eng_payload_o | output | PAY_W | Head entry payload |
| eng_idle_i | input | 1 | Engine has no work in flight |
| reg_we_o | output | 1 | Local register write strobe |
| reg_addr_o | output | 2 | Local register index |
| reg_data_o | output | PAY_W | Local register write data |
| fifo_empty_o | output | 1 | Queue holds no entries |
| fifo_full_o | output | 1 | Queue holds DEPTH entries |
| sync_wait_o | output | 1 | Parser is held by a synchronisation command |

## Verification
A wrong pointer or occupancy count shows up at the engine port within one transfer, as a reordered, duplicated or lost command. It can also show up at once as in_ready_o or the flags disagreeing with the number of commands in flight. A stuck or early release of the wait state shows in sync_wait_o and in_ready_o in the cycle after the release condition is met or missed. A misclassified opcode shows either as a missing write strobe one cycle after acceptance or as an unexpected command at the engine port.

// File: rtl/cmdfe_pkg.sv
package cmdfe_pkg;
  localparam int OP_W      = 4;
  localparam int LOCAL_MAX = 3;
  localparam int SYNC_OP   = 15;

  typedef enum logic [1:0] {
    KIND_LOCAL = 2'd0,
    KIND_FWD   = 2'd1,
    KIND_SYNC  = 2'd2
  } cmd_kind_e;

  function automatic cmd_kind_e classify(input logic [OP_W-1:0] op);
    if (int'(op) <= LOCAL_MAX) return KIND_LOCAL;
    if (int'(op) == SYNC_OP)   return KIND_SYNC;
    return KIND_FWD;
  endfunction
endpackage

// File: rtl/cmd_classifier.sv
module cmd_classifier
  import cmdfe_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output logic            is_local_o,
  output logic            is_fwd_o,
  output logic            is_sync_o
);
  cmd_kind_e kind;
  always_comb begin
    kind       = classify(op_i);
    is_local_o = (kind == KIND_LOCAL);
    is_fwd_o   = (kind == KIND_FWD);
    is_sync_o  = (kind == KIND_SYNC);
  end
endmodule

// File: rtl/cmd_fifo.sv
module cmd_fifo #(
  parameter int W     = 36,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty_o = (count == '0);
  assign full_o  = (count == FULL);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem[rptr];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/cmd_sync_ctrl.sv
module cmd_sync_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_fire_i,
  input  logic fifo_empty_i,
  input  logic eng_idle_i,
  output logic wait_o
);
  // Hold from SYNC acceptance until queue drained and engine idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              wait_o <= 1'b0;
    else if (sync_fire_i)                     wait_o <= 1'b1;
    else if (wait_o && fifo_empty_i && eng_idle_i) wait_o <= 1'b0;
  end
endmodule

// File: rtl/cmd_frontend.sv
module cmd_frontend
  import cmdfe_pkg::*;
#(
  parameter int PAY_W = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [3:0]       in_opcode_i,
  input  logic [PAY_W-1:0] in_payload_i,
  output logic             eng_valid_o,
  input  logic             eng_ready_i,
  output logic [3:0]       eng_opcode_o,
  output logic [PAY_W-1:0] eng_payload_o,
  input  logic             eng_idle_i,
  output logic             reg_we_o,
  output logic [1:0]       reg_addr_o,
  output logic [PAY_W-1:0] reg_data_o,
  output logic             fifo_empty_o,
  output logic             fifo_full_o,
  output logic             sync_wait_o
);
  localparam int ENT_W = OP_W + PAY_W;

  logic             is_local, is_fwd, is_sync;
  logic             fire, waiting;
  logic [ENT_W-1:0] head;

  cmd_classifier u_cls (
    .op_i       (in_opcode_i),
    .is_local_o (is_local),
    .is_fwd_o   (is_fwd),
    .is_sync_o  (is_sync)
  );

  // Only forwarded commands see queue backpressure
  assign in_ready_o = !waiting && !(is_fwd && fifo_full_o);
  assign fire       = in_valid_i && in_ready_o;

  cmd_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (fire && is_fwd),
    .wdata_i ({in_opcode_i, in_payload_i}),
    .pop_i   (eng_ready_i),
    .rdata_o (head),
    .empty_o (fifo_empty_o),
    .full_o  (fifo_full_o)
  );

  assign eng_valid_o   = !fifo_empty_o;
  assign eng_opcode_o  = head[ENT_W-1:PAY_W];
  assign eng_payload_o = head[PAY_W-1:0];

  cmd_sync_ctrl u_sync (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sync_fire_i  (fire && is_sync),
    .fifo_empty_i (fifo_empty_o),
    .eng_idle_i   (eng_idle_i),
    .wait_o       (waiting)
  );
  assign sync_wait_o = waiting;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_we_o   <= 1'b0;
      reg_addr_o <= '0;
      reg_data_o <= '0;
    end else begin
      reg_we_o <= fire && is_local;
      if (fire && is_local) begin
        reg_addr_o <= in_opcode_i[1:0];
        reg_data_o <= in_payload_i;
      end
    end
  end
endmodule

// File: rtl/cmd_frontend_chk.sv
module cmd_frontend_chk #(
  parameter int PAY_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [3:0]       in_opcode_i,
  input logic             eng_valid_o,
  input logic             eng_ready_i,
  input logic [3:0]       eng_opcode_o,
  input logic [PAY_W-1:0] eng_payload_o,
  input logic             eng_idle_i,
  input logic             reg_we_o,
  input logic [1:0]       reg_addr_o,
  input logic             fifo_empty_o,
  input logic             fifo_full_o,
  input logic             sync_wait_o
);
  // R6
  sync_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_wait_o |-> !in_ready_o);

  // R7
  sync_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_wait_o && fifo_empty_o && eng_idle_i) |=> !sync_wait_o);

  // R4
  full_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_full_o && in_opcode_i >= 4'd4 && in_opcode_i != 4'd15) |-> !in_ready_o);

  // R2
  local_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_opcode_i <= 4'd3)
      |=> (reg_we_o && reg_addr_o == $past(in_opcode_i[1:0])));

  // R9
  hold_head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_valid_o && !eng_ready_i)
      |=> (eng_valid_o && $stable(eng_opcode_o) && $stable(eng_payload_o)));

  // R8
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_empty_o && fifo_full_o) && (eng_valid_o == !fifo_empty_o));

  // R3
  fwd_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_valid_o |-> (eng_opcode_o >= 4'd4 && eng_opcode_o != 4'd15));
endmodule

bind cmd_frontend cmd_frontend_chk #(.PAY_W(PAY_W)) u_chk (.*);

// File: tb/tb_cmd_frontend.sv
`timescale 1ns/1ps
module tb_cmd_frontend;
  localparam int PAY_W = 32;
  localparam int DEPTH = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             in_valid_i = 1'b0;
  logic             in_ready_o;
  logic [3:0]       in_opcode_i = '0;
  logic [PAY_W-1:0] in_payload_i = '0;
  logic             eng_valid_o;
  logic             eng_ready_i = 1'b0;
  logic [3:0]       eng_opcode_o;
  logic [PAY_W-1:0] eng_payload_o;
  logic             eng_idle_i = 1'b1;
  logic             reg_we_o;
  logic [1:0]       reg_addr_o;
  logic [PAY_W-1:0] reg_data_o;
  logic             fifo_empty_o, fifo_full_o, sync_wait_o;

  always #2.5 clk_i = ~clk_i;

  cmd_frontend #(.PAY_W(PAY_W), .DEPTH(DEPTH)) dut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [35:0]      exp_q[$];
  logic             m_wait = 0, exp_we = 0;
  logic [1:0]       exp_addr = '0;
  logic [PAY_W-1:0] exp_data = '0;
  logic             prev_hold = 0;
  logic [35:0]      held = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic bit is_fwd(input logic [3:0] op);
    return op >= 4 && op != 15;
  endfunction

  task automatic step(input logic v, input logic [3:0] op, input logic [PAY_W-1:0] pl,
                      input logic er, input logic idl);
    bit ready_exp, fire, efire, rel;
    int sz;
    @(negedge clk_i);
    // results of the previous edge
    chk(reg_we_o == exp_we, "R2", reg_we_o, exp_we);
    if (exp_we) begin
      chk(reg_addr_o == exp_addr, "R2", reg_addr_o, exp_addr);
      chk(reg_data_o == exp_data, "R2", reg_data_o, exp_data);
    end
    chk(sync_wait_o == m_wait, "R7", sync_wait_o, m_wait);
    chk(fifo_empty_o == (exp_q.size() == 0), "R8", fifo_empty_o, exp_q.size() == 0);
    chk(fifo_full_o == (exp_q.size() == DEPTH), "R8", fifo_full_o, exp_q.size() == DEPTH);
    in_valid_i = v; in_opcode_i = op; in_payload_i = pl; eng_ready_i = er; eng_idle_i = idl;
    #1;
    sz = exp_q.size();
    ready_exp = !m_wait && !(is_fwd(op) && sz == DEPTH);
    if (m_wait)                          chk(in_ready_o == ready_exp, "R6", in_ready_o, ready_exp);
    else if (is_fwd(op) && sz == DEPTH)  chk(in_ready_o == ready_exp, "R4", in_ready_o, ready_exp);
    else if (op <= 3)                    chk(in_ready_o == ready_exp, "R5", in_ready_o, ready_exp);
    else                                 chk(in_ready_o == ready_exp, "R3", in_ready_o, ready_exp);
    chk(eng_valid_o == (sz != 0), "R3", eng_valid_o, sz != 0);
    if (sz != 0) begin
      chk({eng_opcode_o, eng_payload_o} == exp_q[0], "R3", {eng_opcode_o, eng_payload_o}, exp_q[0]);
      if (prev_hold)
        chk({eng_opcode_o, eng_payload_o} == held, "R9", {eng_opcode_o, eng_payload_o}, held);
    end
    fire  = v && ready_exp;
    efire = er && sz != 0;
    prev_hold = (sz != 0) && !er;
    if (sz != 0) held = exp_q[0];
    rel = m_wait && sz == 0 && idl;
    if (efire) void'(exp_q.pop_front());
    if (fire && is_fwd(op)) exp_q.push_back({op, pl});
    if (fire && op == 15) m_wait = 1;
    else if (rel)         m_wait = 0;
    exp_we = fire && op <= 3;
    if (exp_we) begin exp_addr = op[1:0]; exp_data = pl; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    #12;
    // R1 reset state
    chk(in_ready_o == 1, "R1", in_ready_o, 1);
    chk(eng_valid_o == 0, "R1", eng_valid_o, 0);
    chk(fifo_empty_o == 1 && fifo_full_o == 0, "R1", {fifo_empty_o, fifo_full_o}, 2'b10);
    chk(sync_wait_o == 0 && reg_we_o == 0, "R1", {sync_wait_o, reg_we_o}, 0);
    @(negedge clk_i); rst_ni = 1;

    // R4: fill the queue with the engine stalled
    for (int i = 0; i < DEPTH + 2; i++) step(1, 4'(4 + i % 11), PAY_W'(32'hA000 + i), 0, 0);
    // R5: local writes still accepted while full
    for (int i = 0; i < 4; i++) step(1, 4'(i), PAY_W'(32'hB00 + i), 0, 0);
    // R6/R7: SYNC with busy engine, drain slowly, idle late
    step(1, 4'd15, '0, 0, 0);
    for (int i = 0; i < 6; i++) step(1, 4'd1, '1, 0, 0);
    for (int i = 0; i < 20; i++) step(1, 4'd6, PAY_W'(i), i % 2, 0);
    for (int i = 0; i < 3; i++) step(1, 4'd6, '0, 1, 0);
    step(1, 4'd6, 32'h77, 1, 1);
    step(1, 4'd6, 32'h78, 1, 1);
    // SYNC with an already empty queue and idle engine
    step(0, 4'd0, '0, 1, 1);
    step(1, 4'd15, '0, 1, 1);
    step(1, 4'd2, 32'hC2, 1, 1);
    step(1, 4'd2, 32'hC3, 1, 1);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] op = 4'($urandom % 16);
      if (op == 15 && ($urandom % 4) != 0) op = 4'd5;
      step(($urandom % 4) != 0, op, $urandom,
           (i / 500) % 2 == 0 ? ($urandom % 4) == 0 : ($urandom % 4) != 0,
           ($urandom % 3) != 0);
    end
    for (int i = 0; i < 30; i++) step(0, 4'd0, '0, 1, 1);
    finish_run();
  end
endmodule